// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the slave side of a host processor's register bus. The host places an 8-bit register address and, for writes, a 16-bit word on the bus. It selects the port with an active-low chip select and gives the direction with a read/write line. The port answers with an active-low ready. Behind the port sits a bank of 16-bit registers. A read returns the addressed register's value together with a data output enable. A write stores the host word into the addressed register.

A strap input fixes the timing model. With the strap low, the host runs a free-running handshake. Chip select and data strobe both go low, the port replies with ready, and ready stays asserted until the host lifts either signal. Chip select, data strobe and read/write pass through a two-stage synchronizer before the control logic sees them. Address and data must stay stable while the strobe is low. With the strap high, everything is sampled on the bus clock, the strobe is not used, and ready is a single-cycle pulse.

One register address is the memory data register. An access to it cannot complete while a buffer-memory transfer is still pending. Ready is held back until the clock edge that first samples the pending flag low.

Top module: `host_reg_port`

## Requirements
- R1: After reset, rdy_n is 1, data_oe is 0 and every register in the bank reads as 16'h0000.
- R2: With sync_mode = 1, an idle port that samples cs_n = 0 on a rising clock edge drives rdy_n low right after that edge, whatever ds_n is. rdy_n returns high on the next edge.
- R3: With sync_mode = 0, rdy_n falls on the third rising edge after cs_n and ds_n are both low, because of two synchronizer stages plus the control register. It stays low while both stay low. It rises on the third rising edge after either one goes high.
- R4: rw = 1 is a read: data_out carries the addressed register's value while rdy_n is low. rw = 0 is a write: data_in is stored into the register that addr selects.
- R5: In asynchronous mode a write is stored once per strobe assertion. A change of data_in after rdy_n has fallen, while the strobe is still low, does not alter the register.
- R6: An access to address MDR_ADDR (default 8'h0F) while xfer_pending = 1 keeps rdy_n high. rdy_n falls right after the first rising edge that samples xfer_pending = 0 with the request still present. If xfer_pending falls in the same cycle that the request arrives, no stall occurs.
- R7: Addresses at or above NUM_REGS (default 16) are acknowledged as usual. Reads from them return 16'h0000, and writes to them change no register, including the register that shares their low address bits.
- R8: data_oe is high only while rdy_n is low during a read acknowledge. It is never high during a write or while rdy_n is high.
- R9: With sync_mode = 0, chip select low with the strobe high, or the strobe low with chip select high, is no transaction. rdy_n stays high and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | Strap: 1 = clocked bus, 0 = strobe/ready handshake |
| cs_n | input | 1 | Active-low chip select |
| ds_n | input | 1 | Active-low data strobe, used in asynchronous mode only |
| rw | input | 1 | 1 = read from port, 0 = write into port |
| addr | input | 8 | Register address |
| data_in | input | 16 | Write data from the host |
| data_out | output | 16 | Read data to the host |
| data_oe | output | 1 | Output enable for data_out; bus released when 0 |
| rdy_n | output | 1 | Active-low transfer acknowledge |
| xfer_pending | input | 1 | A buffer-memory transfer is still in progress |

## Verification
Two events can meet on one edge: the arrival of a request for the memory data register, and the change of the pending-transfer flag. The bench drives both in the same half-cycle in both directions. The flag falling together with a synchronous request must give ready one cycle later with no stall. The flag rising together with a request must hold ready high until the flag drops, and ready then follows on the very next edge. Read data in both cases is checked against a scoreboard.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  localparam int HRP_AW = 8;
  localparam int HRP_DW = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } hrp_state_e;

  // A request is present: clocked bus needs only the select, the handshake needs both.
  function automatic logic req_present(input logic sync_md, input logic cs_lo, input logic ds_lo);
    return sync_md ? cs_lo : (cs_lo && ds_lo);
  endfunction

  // Address maps onto a register of the bank.
  function automatic logic addr_in_bank(input logic [31:0] a, input int unsigned n_regs);
    return a < n_regs;
  endfunction

  // Address is the one register whose access waits on buffer memory.
  function automatic logic addr_is_mdr(input logic [31:0] a, input logic [31:0] mdr);
    return a == mdr;
  endfunction

endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
#(
  parameter int AW = HRP_AW,
  parameter int DW = HRP_DW,
  parameter logic [AW-1:0] MDR_ADDR = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          req,
  input  logic          rw_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          xfer_pending,
  output logic          fire,
  output logic          fire_rw,
  output logic [AW-1:0] fire_addr,
  output logic [DW-1:0] fire_wdata,
  output logic          rdy_n,
  output logic          rd_oe
);

  hrp_state_e    state, state_nx;
  logic          lat_rw;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          mdr_hit;
  logic          stall_enter;
  logic          take_req;

  // Inputs are taken live when idle, from the latch once a request is in flight.
  always_comb begin
    if (state == ST_IDLE) begin
      fire_addr  = addr_in;
      fire_rw    = rw_in;
      fire_wdata = wdata_in;
    end else begin
      fire_addr  = lat_addr;
      fire_rw    = lat_rw;
      fire_wdata = lat_wdata;
    end
  end

  assign mdr_hit     = addr_is_mdr(32'(fire_addr), 32'(MDR_ADDR));
  assign take_req    = (state == ST_IDLE) && req;
  assign stall_enter = take_req && mdr_hit && xfer_pending;
  assign fire        = (take_req && !stall_enter) ||
                       ((state == ST_WAIT) && req && !xfer_pending);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (stall_enter) state_nx = ST_WAIT;
        else if (fire)   state_nx = sync_mode ? ST_ACK : ST_HOLD;
      end
      ST_WAIT: begin
        if (!req)      state_nx = ST_IDLE;
        else if (fire) state_nx = sync_mode ? ST_ACK : ST_HOLD;
      end
      ST_ACK:  state_nx = ST_IDLE;
      ST_HOLD: if (!req) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_rw    <= 1'b1;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      state <= state_nx;
      if (take_req) begin
        lat_rw    <= rw_in;
        lat_addr  <= addr_in;
        lat_wdata <= wdata_in;
      end
    end
  end

  assign rdy_n = !((state == ST_ACK) || (state == ST_HOLD));
  assign rd_oe = !rdy_n && lat_rw;

  // Clocked-bus acknowledge lasts exactly one cycle.
  assert_sync_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !rdy_n) |=> rdy_n);

  // Handshake acknowledge holds while the synchronized request stays present.
  assert_async_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !rdy_n && req) |=> !rdy_n);

  // A stalled access keeps ready released while the transfer is pending.
  assert_mdr_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT) && xfer_pending) |=> rdy_n);

endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank
  import hrp_pkg::*;
#(
  parameter int AW       = HRP_AW,
  parameter int DW       = HRP_DW,
  parameter int NUM_REGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          fire_rw,
  input  logic [AW-1:0] fire_addr,
  input  logic [DW-1:0] fire_wdata,
  output logic [DW-1:0] rdata
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DW-1:0] mem;
  logic                        hit;
  logic [IDX_W-1:0]            idx;
  logic                        wr_en;
  logic                        rd_en;
  logic [DW-1:0]               rdata_q;

  assign hit   = addr_in_bank(32'(fire_addr), NUM_REGS);
  assign idx   = fire_addr[IDX_W-1:0];
  assign wr_en = fire && !fire_rw;
  assign rd_en = fire && fire_rw;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (wr_en && hit && (idx == IDX_W'(g)))
          mem[g] <= fire_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= hit ? mem[idx] : '0;
  end

  assign rdata = rdata_q;

  // A store lands the host word in the selected register.
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> (mem[$past(idx)] == $past(fire_wdata)));

  // Never two stores in consecutive cycles: one store per strobe.
  assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // Unmapped stores leave the whole bank untouched.
  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(mem));

endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter int AW          = HRP_AW,
  parameter int DW          = HRP_DW,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] MDR_ADDR = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          cs_n,
  input  logic          ds_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          rdy_n,
  input  logic          xfer_pending
);

  logic [2:0]    ctl_raw, ctl_s;
  logic          cs_n_s, ds_n_s, rw_s;
  logic          req, rw_eff;
  logic          fire, fire_rw;
  logic [AW-1:0] fire_addr;
  logic [DW-1:0] fire_wdata;
  logic          rd_oe;

  assign ctl_raw = {cs_n, ds_n, rw};

  hrp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  assign {cs_n_s, ds_n_s, rw_s} = ctl_s;

  assign req    = sync_mode ? req_present(1'b1, !cs_n, 1'b1)
                            : req_present(1'b0, !cs_n_s, !ds_n_s);
  assign rw_eff = sync_mode ? rw : rw_s;

  hrp_ctrl #(.AW(AW), .DW(DW), .MDR_ADDR(MDR_ADDR)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_mode    (sync_mode),
    .req          (req),
    .rw_in        (rw_eff),
    .addr_in      (addr),
    .wdata_in     (data_in),
    .xfer_pending (xfer_pending),
    .fire         (fire),
    .fire_rw      (fire_rw),
    .fire_addr    (fire_addr),
    .fire_wdata   (fire_wdata),
    .rdy_n        (rdy_n),
    .rd_oe        (rd_oe)
  );

  hrp_regbank #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_rw    (fire_rw),
    .fire_addr  (fire_addr),
    .fire_wdata (fire_wdata),
    .rdata      (data_out)
  );

  assign data_oe = rd_oe;

  // Output enable only ever accompanies an active acknowledge.
  assert_oe_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !rdy_n);

  // Output enable rises only after an access that was a read.
  assert_oe_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(fire && fire_rw));

endmodule

// File: tb/tb_host_reg_port.sv
`timescale 1ns/1ps
module tb_host_reg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_mode = 1'b1;
  logic        cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        data_oe, rdy_n;
  logic        xfer_pending = 1'b0;

  int checks = 0, failures = 0, oe_viol = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  host_reg_port dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .cs_n(cs_n), .ds_n(ds_n),
    .rw(rw), .addr(addr), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .rdy_n(rdy_n), .xfer_pending(xfer_pending)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Monitor: pops an expected read word on every falling ready with output enabled.
  initial begin
    logic prev_rdy;
    prev_rdy = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (data_oe && rdy_n) oe_viol++;
        if (!rdy_n && prev_rdy && data_oe) begin
          if (exp_q.size() == 0) chk(0, "R4 unexpected read ack", 32'(data_out), 0);
          else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(data_out === e, t, 32'(data_out), 32'(e));
          end
        end
        prev_rdy = rdy_n;
      end
    end
  end

  task automatic expect_read(input logic [15:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // Clocked-bus access; returns after the bus is released.
  task automatic sync_acc(input logic rw_i, input logic [7:0] a, input logic [15:0] d,
                          input logic ds_i, input logic pend_i, input int exp_lat, input string t);
    int lat;
    @(negedge clk);
    cs_n = 1'b0; ds_n = ds_i; rw = rw_i; addr = a; data_in = d; xfer_pending = pend_i;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (rdy_n && lat < 40);
    chk(lat == exp_lat, {t, " ready latency"}, 32'(lat), 32'(exp_lat));
    @(negedge clk);
    cs_n = 1'b1; ds_n = 1'b1;
    @(posedge clk); #1;
    chk(rdy_n == 1'b1, "R2 ready pulse ends", 32'(rdy_n), 1);
  endtask

  // Strobe/ready handshake access.
  task automatic async_acc(input logic rw_i, input logic [7:0] a, input logic [15:0] d,
                           input bit wiggle, input string t);
    int lat;
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b0; rw = rw_i; addr = a; data_in = d;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (rdy_n && lat < 40);
    chk(lat == 3, {t, " R3 assert latency"}, 32'(lat), 3);
    if (wiggle) begin
      @(negedge clk); data_in = ~d;
      repeat (4) @(posedge clk);
      #1 chk(rdy_n == 1'b0, "R3 ready held", 32'(rdy_n), 0);
    end
    @(negedge clk);
    ds_n = 1'b1;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (!rdy_n && lat < 40);
    chk(lat == 3, {t, " R3 release latency"}, 32'(lat), 3);
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rdy_n == 1'b1 && data_oe == 1'b0, "R1 reset outputs", {rdy_n, data_oe}, 2'b10);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Clocked mode
    sync_mode = 1'b1;
    expect_read(16'h0000, "R1 reset register value");
    sync_acc(1'b1, 8'h05, '0, 1'b1, 1'b0, 1, "R2 read");
    sync_acc(1'b0, 8'h00, 16'h5A5A, 1'b1, 1'b0, 1, "R2 write ds high ignored");
    sync_acc(1'b0, 8'h07, 16'hC3C3, 1'b0, 1'b0, 1, "R2 write");
    expect_read(16'h5A5A, "R4 read reg0");
    sync_acc(1'b1, 8'h00, '0, 1'b1, 1'b0, 1, "R4 read");
    expect_read(16'hC3C3, "R4 read reg7");
    sync_acc(1'b1, 8'h07, '0, 1'b0, 1'b0, 1, "R4 read");

    // R7 unmapped alias of reg0
    sync_acc(1'b0, 8'h80, 16'h1234, 1'b1, 1'b0, 1, "R7 unmapped write acked");
    expect_read(16'h0000, "R7 unmapped read zero");
    sync_acc(1'b1, 8'h80, '0, 1'b1, 1'b0, 1, "R7 unmapped read");
    expect_read(16'h5A5A, "R7 alias untouched");
    sync_acc(1'b1, 8'h00, '0, 1'b1, 1'b0, 1, "R7 reg0 read");

    // R6 stall on memory data register
    @(negedge clk);
    xfer_pending = 1'b1; cs_n = 1'b0; rw = 1'b0; addr = 8'h0F; data_in = 16'hBEEF;
    repeat (5) @(posedge clk);
    #1 chk(rdy_n == 1'b1, "R6 stalled while pending", 32'(rdy_n), 1);
    @(negedge clk) xfer_pending = 1'b0;
    @(posedge clk); #1;
    chk(rdy_n == 1'b0, "R6 ready after pending clears", 32'(rdy_n), 0);
    @(negedge clk) cs_n = 1'b1;
    @(posedge clk);
    expect_read(16'hBEEF, "R6 stalled write stored");
    sync_acc(1'b1, 8'h0F, '0, 1'b1, 1'b0, 1, "R6 read mdr");
    // pending falls in the same cycle the request arrives: no stall
    @(negedge clk) xfer_pending = 1'b1;
    @(posedge clk);
    expect_read(16'hBEEF, "R6 same-cycle release read");
    sync_acc(1'b1, 8'h0F, '0, 1'b1, 1'b0, 1, "R6 same-cycle release");
    // pending rises in the same cycle the request arrives: stall
    @(negedge clk);
    xfer_pending = 1'b1; cs_n = 1'b0; rw = 1'b1; addr = 8'h0F;
    expect_read(16'hBEEF, "R6 same-cycle stall read");
    @(posedge clk); #1;
    chk(rdy_n == 1'b1, "R6 same-cycle stall", 32'(rdy_n), 1);
    @(negedge clk) xfer_pending = 1'b0;
    @(posedge clk); #1;
    chk(rdy_n == 1'b0, "R6 ready next edge", 32'(rdy_n), 0);
    @(negedge clk) cs_n = 1'b1;
    repeat (2) @(posedge clk);

    // Handshake mode
    sync_mode = 1'b0;
    repeat (4) @(posedge clk);
    async_acc(1'b0, 8'h03, 16'hA1B2, 1'b1, "R5 write with data change");
    expect_read(16'hA1B2, "R5 first word kept");
    async_acc(1'b1, 8'h03, '0, 1'b0, "R4 async read");
    expect_read(16'hC3C3, "R4 async read reg7");
    async_acc(1'b1, 8'h07, '0, 1'b1, "R4 async held read");

    // R9 incomplete selects
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b1; rw = 1'b0; addr = 8'h03; data_in = 16'hFFFF;
    repeat (8) @(posedge clk);
    #1 chk(rdy_n == 1'b1, "R9 cs only", 32'(rdy_n), 1);
    @(negedge clk); cs_n = 1'b1; ds_n = 1'b0;
    repeat (8) @(posedge clk);
    #1 chk(rdy_n == 1'b1, "R9 ds only", 32'(rdy_n), 1);
    @(negedge clk); ds_n = 1'b1; rw = 1'b1;
    repeat (4) @(posedge clk);
    expect_read(16'hA1B2, "R9 register unchanged");
    async_acc(1'b1, 8'h03, '0, 1'b0, "R9 readback");

    // R6 in handshake mode
    @(negedge clk);
    xfer_pending = 1'b1; cs_n = 1'b0; ds_n = 1'b0; rw = 1'b0; addr = 8'h0F; data_in = 16'h7E57;
    repeat (8) @(posedge clk);
    #1 chk(rdy_n == 1'b1, "R6 async stall", 32'(rdy_n), 1);
    @(negedge clk) xfer_pending = 1'b0;
    @(posedge clk); #1;
    chk(rdy_n == 1'b0, "R6 async ready after pending", 32'(rdy_n), 0);
    @(negedge clk) ds_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk(rdy_n == 1'b1, "R3 release after stall", 32'(rdy_n), 1);
    @(negedge clk) cs_n = 1'b1; rw = 1'b1;
    repeat (3) @(posedge clk);
    expect_read(16'h7E57, "R6 async stalled write stored");
    async_acc(1'b1, 8'h0F, '0, 1'b0, "R6 async readback");

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R4 all reads seen", 32'(exp_q.size()), 0);
    chk(oe_viol == 0, "R8 oe only during read ack", 32'(oe_viol), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule